// File: doc/BRIEF.md
# Cascadable LCD Segment Data Loader

This block is the digital data path of an 80-column LCD segment driver. Display data arrives in one of two ways. In serial mode one bit arrives per shift-clock pulse on one pin. In nibble mode four bits arrive per pulse on a 4-bit bus. The data shifts into an 80-bit staging register, in a direction that an input selects. When the line-latch clock falls, the staging register is copied into an 80-bit output latch. That latch is the output word of the block.

Several loaders can share one data bus through a pair of chained enable pins. A loader accepts shift pulses only while its active enable input is low. Once it holds a full line, it stops accepting pulses and pulls its active enable output low, which hands the bus to the next loader in the chain. While the line-latch clock is high, every loader restarts for the next line.

The shift and line clocks are ordinary inputs. They are sampled on the system clock and edge-detected.

The control is a three-state machine:
- `LD_IDLE`: no pulse has been accepted on this line yet.
- `LD_RUN`: at least one pulse has been accepted, but the line is not complete.
- `LD_FULL`: the line is complete and the active enable output is low.

The named transitions are:
- `T_FIRST` (IDLE to RUN): the first accepted pulse.
- `T_NEXT` (RUN to RUN): a further accepted pulse that does not complete the line.
- `T_DONE` (IDLE or RUN to FULL): the pulse that completes the line.
- `T_RESTART` (any state to IDLE): the line clock is high.

Top module: `lcd_seg_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the staging register and `seg_q` are cleared, the load count is cleared, and both enable outputs are high.
- R2: In serial mode (`ser_mode`=1) with `dir_rev`=0, an accepted pulse shifts the staging register toward higher indices and puts `din[0]` at index 0. `din[3:1]` has no effect.
- R3: In serial mode with `dir_rev`=1, an accepted pulse shifts toward lower indices and puts `din[0]` at index 79.
- R4: In nibble mode (`ser_mode`=0) with `dir_rev`=0, an accepted pulse shifts by four places toward higher indices. It puts `din[0]`..`din[3]` at indices 0..3.
- R5: In nibble mode with `dir_rev`=1, an accepted pulse shifts by four places toward lower indices. It puts `din[0]`, `din[1]`, `din[2]` and `din[3]` at indices 79, 78, 77 and 76.
- R6: `seg_q` takes the staging value on the clock edge at which `line_clk` is seen low after having been high. At every other edge `seg_q` holds its value.
- R7: A shift pulse is ignored while the active enable input is high. The active enable input is `chain_l_i` when `dir_rev`=0 and `chain_r_i` when `dir_rev`=1.
- R8: The active enable output goes low one edge after the 80th accepted pulse (serial mode) or the 20th accepted pulse (nibble mode). Later pulses are ignored until a restart.
- R9: While `line_clk` is high, the load count clears, pulses are ignored, and both enable outputs read high from the next edge on.
- R10: When `dir_rev`=0, `chain_r_o` is the active enable output and `chain_l_o` stays high. When `dir_rev`=1 the two swap. The two outputs are never low together.
- R11: One shift pulse is one rising edge of the sampled `shift_clk`. A pulse held high for many clock cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Shift pulse; sampled, rising edge used |
| line_clk | input | 1 | Line-latch clock; falling edge latches, high level restarts |
| ser_mode | input | 1 | 1 = serial loading, 0 = nibble loading |
| dir_rev | input | 1 | 0 = shift toward higher indices, 1 = toward lower indices |
| din | input | 4 | Data bus; only bit 0 is used in serial mode |
| chain_l_i | input | 1 | Left enable input, active low (used when dir_rev=0) |
| chain_r_i | input | 1 | Right enable input, active low (used when dir_rev=1) |
| chain_l_o | output | 1 | Left enable output (active when dir_rev=1) |
| chain_r_o | output | 1 | Right enable output (active when dir_rev=0) |
| seg_q | output | 80 | Latched line data |

## Verification
The assertions assume that `shift_clk` and `line_clk` change synchronously with `clk`. They also assume that `dir_rev` and `ser_mode` are held steady for the whole of a line. The bench drives every input on the falling edge of the system clock and changes direction and mode only between lines. Shift pulses last at least one cycle high and one cycle low. A line clock never falls on the same edge as an accepted shift pulse, which keeps the latch value clear of any same-edge ordering question.

// File: rtl/lcdl_pkg.sv
package lcdl_pkg;
    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_RUN  = 2'd1,
        LD_FULL = 2'd2
    } ld_state_t;
endpackage

// File: rtl/lcdl_edge.sv
module lcdl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_d;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_d <= 1'b0;
        else        sig_d <= sig;
    end

    assign rise = sig & ~sig_d;
    assign fall = ~sig & sig_d;
endmodule

// File: rtl/lcdl_stage.sv
module lcdl_stage #(
    parameter int NCH = 80,
    parameter int NIB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           ser_mode,
    input  logic           dir_rev,
    input  logic [NIB-1:0] din,
    output logic [NCH-1:0] stage
);
    logic [NIB-1:0] din_flip;

    // bus bit 0 lands first in the direction of travel
    for (genvar j = 0; j < NIB; j++) begin : g_flip
        assign din_flip[j] = din[NIB-1-j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (step) begin
            unique case ({ser_mode, dir_rev})
                2'b10:   stage <= {stage[NCH-2:0], din[0]};
                2'b11:   stage <= {din[0], stage[NCH-1:1]};
                2'b00:   stage <= {stage[NCH-NIB-1:0], din};
                default: stage <= {din_flip, stage[NCH-1:NIB]};
            endcase
        end
    end
endmodule

// File: rtl/lcdl_ctrl.sv
module lcdl_ctrl
    import lcdl_pkg::*;
#(
    parameter int NCH = 80,
    parameter int NIB = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_req,
    input  logic restart,
    input  logic ser_mode,
    output logic step,
    output logic full
);
    localparam int NGRP = NCH / NIB;
    localparam int CW   = $clog2(NCH + 1);

    ld_state_t   state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          last;

    assign limit = ser_mode ? CW'(NCH) : CW'(NGRP);
    assign last  = (cnt + CW'(1)) >= limit;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            LD_IDLE, LD_RUN: if (step) nxt = last ? LD_FULL : LD_RUN;
            LD_FULL:         nxt = LD_FULL;
            default:         nxt = LD_IDLE;
        endcase
        if (restart) nxt = LD_IDLE;
    end

    // state register and pulse count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LD_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (restart)   cnt <= '0;
            else if (step) cnt <= cnt + CW'(1);
        end
    end

    // outputs
    always_comb begin
        step = 1'b0;
        full = 1'b0;
        unique case (state)
            LD_IDLE, LD_RUN: step = shift_req & ~restart;
            LD_FULL:         full = 1'b1;
            default:         step = 1'b0;
        endcase
    end
endmodule

// File: rtl/lcd_seg_loader.sv
module lcd_seg_loader #(
    parameter int NCH = 80,
    parameter int NIB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_clk,
    input  logic           line_clk,
    input  logic           ser_mode,
    input  logic           dir_rev,
    input  logic [NIB-1:0] din,
    input  logic           chain_l_i,
    input  logic           chain_r_i,
    output logic           chain_l_o,
    output logic           chain_r_o,
    output logic [NCH-1:0] seg_q
);
    logic           s_rise, s_fall, l_rise, l_fall;
    logic           chain_in, shift_req, step, full;
    logic [NCH-1:0] stage;

    lcdl_edge u_sedge (.clk(clk), .rst_n(rst_n), .sig(shift_clk), .rise(s_rise), .fall(s_fall));
    lcdl_edge u_ledge (.clk(clk), .rst_n(rst_n), .sig(line_clk),  .rise(l_rise), .fall(l_fall));

    assign chain_in  = dir_rev ? chain_r_i : chain_l_i;
    assign shift_req = s_rise & ~chain_in;

    lcdl_ctrl #(.NCH(NCH), .NIB(NIB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .shift_req(shift_req), .restart(line_clk),
        .ser_mode(ser_mode), .step(step), .full(full)
    );

    lcdl_stage #(.NCH(NCH), .NIB(NIB)) u_stage (
        .clk(clk), .rst_n(rst_n), .step(step), .ser_mode(ser_mode),
        .dir_rev(dir_rev), .din(din), .stage(stage)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      seg_q <= '0;
        else if (l_fall) seg_q <= stage;
    end

    assign chain_l_o = dir_rev ? ~full : 1'b1;
    assign chain_r_o = dir_rev ? 1'b1  : ~full;
endmodule

// File: rtl/lcd_seg_loader_chk.sv
module lcd_seg_loader_chk #(
    parameter int NCH = 80
) (
    input logic           clk,
    input logic           rst_n,
    input logic           line_clk,
    input logic           dir_rev,
    input logic           chain_l_i,
    input logic           chain_r_i,
    input logic           chain_l_o,
    input logic           chain_r_o,
    input logic [NCH-1:0] seg_q,
    input logic [NCH-1:0] stage
);
    logic act_in, act_out;
    assign act_in  = dir_rev ? chain_r_i : chain_l_i;
    assign act_out = dir_rev ? chain_l_o : chain_r_o;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (seg_q == '0 && stage == '0 && chain_l_o && chain_r_o)); // R1
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(!line_clk && $past(line_clk)) |=> $stable(seg_q)); // R6
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) act_in |=> $stable(stage)); // R7
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !act_out |=> $stable(stage)); // R8
    AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n) line_clk |=> (chain_l_o && chain_r_o)); // R9
    AST_ONE_SIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !(!chain_l_o && !chain_r_o)); // R10
endmodule

bind lcd_seg_loader lcd_seg_loader_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .dir_rev(dir_rev),
    .chain_l_i(chain_l_i), .chain_r_i(chain_r_i), .chain_l_o(chain_l_o),
    .chain_r_o(chain_r_o), .seg_q(seg_q), .stage(stage)
);

// File: tb/tb_lcd_seg_loader.sv
module tb_lcd_seg_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_clk = 1'b0, line_clk = 1'b0;
    logic        ser_mode = 1'b1, dir_rev = 1'b0;
    logic [3:0]  din = 4'd0;
    logic        chain_l_i = 1'b0, chain_r_i = 1'b1;
    logic        chain_l_o, chain_r_o;
    logic [79:0] seg_q;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lcd_seg_loader dut (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .line_clk(line_clk),
        .ser_mode(ser_mode), .dir_rev(dir_rev), .din(din),
        .chain_l_i(chain_l_i), .chain_r_i(chain_r_i),
        .chain_l_o(chain_l_o), .chain_r_o(chain_r_o), .seg_q(seg_q)
    );

    // behavioural reference, stepped on every rising clock edge
    logic [79:0] m_stage = '0, m_latch = '0;
    int  m_cnt = 0;
    bit  m_full = 1'b0, m_sp = 1'b0, m_lp = 1'b0;

    always @(posedge clk) begin
        bit rise, fall, ain;
        int nb;
        rise = shift_clk && !m_sp;
        fall = !line_clk && m_lp;
        if (!rst_n) begin
            m_stage = '0; m_latch = '0; m_cnt = 0; m_full = 1'b0;
            m_sp = 1'b0; m_lp = 1'b0;
        end else begin
            if (fall) m_latch = m_stage;
            ain = dir_rev ? chain_r_i : chain_l_i;
            if (line_clk) begin
                m_cnt = 0; m_full = 1'b0;
            end else if (rise && !ain && !m_full) begin
                nb = ser_mode ? 1 : 4;
                if (!dir_rev) begin
                    m_stage = m_stage << nb;
                    for (int j = 0; j < nb; j++) m_stage[j] = din[j];
                end else begin
                    m_stage = m_stage >> nb;
                    for (int j = 0; j < nb; j++) m_stage[79-j] = din[j];
                end
                m_cnt++;
                if (m_cnt >= (ser_mode ? 80 : 20)) m_full = 1'b1;
            end
            m_sp = shift_clk;
            m_lp = line_clk;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        bit el, er;
        el = dir_rev ? !m_full : 1'b1;
        er = dir_rev ? 1'b1 : !m_full;
        checks++;
        if (seg_q !== m_latch) begin
            fails++;
            $display("FAIL R6 latch word: actual %h expected %h", seg_q, m_latch);
        end
        checks++;
        if (chain_l_o !== el || chain_r_o !== er) begin
            fails++;
            $display("FAIL R10 enable outputs: actual %b%b expected %b%b", chain_l_o, chain_r_o, el, er);
        end
    end

    task automatic chk_vec(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] d);
        @(negedge clk); din = d; shift_clk = 1'b1;
        @(negedge clk); shift_clk = 1'b0;
    endtask

    task automatic line_pulse();
        @(negedge clk); line_clk = 1'b1;
        @(negedge clk); line_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [79:0] exp;
        logic [3:0]  nib;
        logic        b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_vec("R1 reset word", seg_q, '0);
        chk_bit("R1 reset left enable", chain_l_o, 1'b1);
        chk_bit("R1 reset right enable", chain_r_o, 1'b1);

        // serial, left to right; upper bus bits toggled (R2)
        ser_mode = 1'b1; dir_rev = 1'b0; chain_l_i = 1'b0; chain_r_i = 1'b1;
        exp = '0;
        for (int k = 0; k < 80; k++) begin
            b = (k % 3 == 0);
            exp[79-k] = b;
            pulse({k[2:0], b});
        end
        chk_bit("R8 serial full after 80", chain_r_o, 1'b0);
        chk_vec("R6 no latch before line clock", seg_q, '0);
        repeat (3) pulse(4'hF);
        line_pulse();
        chk_vec("R2 serial left-to-right word", seg_q, exp);
        chk_bit("R9 restart releases enable", chain_r_o, 1'b1);

        // serial, right to left
        dir_rev = 1'b1; chain_l_i = 1'b1; chain_r_i = 1'b0;
        exp = '0;
        for (int k = 0; k < 80; k++) begin
            b = (k % 5 < 2);
            exp[k] = b;
            pulse({3'b000, b});
        end
        chk_bit("R10 reversed active output low", chain_l_o, 1'b0);
        chk_bit("R10 reversed idle output high", chain_r_o, 1'b1);
        line_pulse();
        chk_vec("R3 serial right-to-left word", seg_q, exp);

        // nibble, left to right
        ser_mode = 1'b0; dir_rev = 1'b0; chain_l_i = 1'b0; chain_r_i = 1'b1;
        exp = '0;
        for (int k = 0; k < 20; k++) begin
            nib = 4'(k * 7 + 3);
            for (int j = 0; j < 4; j++) exp[4*(19-k)+j] = nib[j];
            pulse(nib);
            if (k == 18) chk_bit("R8 nibble not full after 19", chain_r_o, 1'b1);
        end
        chk_bit("R8 nibble full after 20", chain_r_o, 1'b0);
        line_pulse();
        chk_vec("R4 nibble left-to-right word", seg_q, exp);

        // nibble, right to left
        dir_rev = 1'b1; chain_l_i = 1'b1; chain_r_i = 1'b0;
        exp = '0;
        for (int k = 0; k < 20; k++) begin
            nib = 4'(k * 5 + 9);
            for (int j = 0; j < 4; j++) exp[4*k+3-j] = nib[j];
            pulse(nib);
        end
        line_pulse();
        chk_vec("R5 nibble right-to-left word", seg_q, exp);

        // enable input high: pulses ignored, staging unchanged
        chain_r_i = 1'b1;
        repeat (6) pulse(4'hF);
        chk_bit("R7 disabled keeps enable high", chain_l_o, 1'b1);
        line_pulse();
        chk_vec("R7 disabled pulses leave data", seg_q, exp);

        // long high pulse counts once
        chain_r_i = 1'b0;
        @(negedge clk); din = 4'hA; shift_clk = 1'b1;
        repeat (5) @(negedge clk);
        shift_clk = 1'b0;
        for (int k = 0; k < 18; k++) pulse(4'(k));
        chk_bit("R11 held pulse counted once (19)", chain_l_o, 1'b1);
        pulse(4'h3);
        chk_bit("R11 full at 20th edge", chain_l_o, 1'b0);
        line_pulse();

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule